// File: doc/BRIEF.md
# Receive Transport Overhead Nibble Extractor

This block copies every section and line overhead octet of a received STS-48 frame onto a 4-bit port so that an external device can process them. Upstream logic delivers the frame as bytes. A strobe marks each byte, a qualifier says whether the byte belongs to the transport overhead, and a start flag marks the first A1 octet of the frame. Overhead bytes go into a small buffer. A serialiser empties the buffer onto the 4-bit port, high nibble first, without changing the order of the bytes.

The port clock (38.88 MHz, 50% duty) is not a separate clock input. It is a one-cycle enable, `port_tick`, that marks each falling edge of the port clock in the system clock domain. The outputs change only on cycles where `port_tick` is high. The overhead arrives in bursts, one row at a time. The port needs 2592 nibble slots per frame (9 rows × 144 columns × 2) and has more slots than that. On the spare slots the valid strobe is inactive. The buffer holds one complete row of overhead. If a byte reaches a full buffer it is dropped, and a sticky error flag is set.

Top module: `rtoh_extract`

## Requirements
- R1: Overhead bytes (accepted when `in_valid`=1 and `in_oh`=1) leave on `toh_nib` in the same order in which they were accepted.
- R2: Each byte takes two consecutive port slots. Its bits [7:4] go out first and its bits [3:0] second. `toh_nib[3]` carries the most significant bit of each nibble.
- R3: `toh_fp` is high for exactly one port slot: the slot that carries the high nibble of a byte accepted with `in_sof`=1. It is low in every other slot.
- R4: On a port slot with no data to send, `toh_valid` is at its inactive level and `toh_nib` and `toh_fp` are 0.
- R5: `valid_pol`=1 makes `toh_valid` active-high, and `valid_pol`=0 makes it active-low.
- R6: `toh_nib`, `toh_fp` and the active state of `toh_valid` change only in the clock cycle that follows a cycle with `port_tick`=1.
- R7: A byte offered with `in_oh`=0, or with `in_valid`=0, never appears on the port.
- R8: The buffer holds DEPTH bytes (default 256, at least one 144-octet row). While it has room, a burst is accepted with no loss, and `ovf_err` stays 0.
- R9: A byte accepted into a full buffer (with no read in the same cycle) is discarded. `ovf_err` then goes to 1 and stays at 1 until reset. The bytes already held still come out in order.
- R10: After reset, `toh_nib`=0, `toh_fp`=0, `ovf_err`=0, `toh_valid` is at its inactive level, and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (line byte) clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | A received byte is present on `in_byte` |
| in_byte | input | 8 | Received byte |
| in_oh | input | 1 | The byte is transport overhead |
| in_sof | input | 1 | The byte is the first A1 octet of the frame |
| port_tick | input | 1 | One-cycle marker of a port clock falling edge |
| valid_pol | input | 1 | Active level of `toh_valid` (1 = active-high) |
| toh_nib | output | 4 | Overhead nibble, MSB on bit 3 |
| toh_valid | output | 1 | A nibble is present on `toh_nib` (polarity set by `valid_pol`) |
| toh_fp | output | 1 | Frame pulse on the first nibble of the first A1 octet |
| ovf_err | output | 1 | Sticky buffer overflow flag |

## Verification
If a buffer pointer is corrupted, the port shows a byte out of order, repeated or missing within one or two slots of the read that fails. The bench compares the whole captured nibble stream against the bytes it sent. If the nibble-phase state goes wrong, a byte shows up with its halves swapped, or the frame pulse lands on a low nibble, at the slot where it happens. If the full-buffer accounting goes wrong, it shows only at the drain after an overflow: the nibble count or the contents differ, or `ovf_err` clears. The bench therefore drives the buffer past full, drains it, and checks the exact count and order of what comes out.

// File: rtl/rtoh_pkg.sv
package rtoh_pkg;
  localparam int OCT_W = 8;
  localparam int NIB_W = 4;

  // One buffered overhead byte with its frame-start tag
  typedef struct packed {
    logic             sof;
    logic [OCT_W-1:0] octet;
  } oh_word_t;
endpackage

// File: rtl/rtoh_fifo.sv
module rtoh_fifo
  import rtoh_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  oh_word_t wdata,
  input  logic     pop,
  output oh_word_t rdata,
  output logic     empty,
  output logic     ovf_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  oh_word_t        mem [DEPTH];
  logic [PW-1:0]   wr_q, wr_n, rd_q, rd_n;
  logic [PW-1:0]   fill;
  logic            ovf_q, ovf_n;
  logic            full, accept;

  assign fill   = wr_q - rd_q;
  assign full   = (fill == DEPTH_P);
  assign empty  = (fill == '0);
  assign accept = push && (!full || pop);
  assign rdata  = mem[rd_q[AW-1:0]];
  assign ovf_err = ovf_q;

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    ovf_n = ovf_q;
    if (accept)
      wr_n = (wr_q[AW-1:0] == AW'(DEPTH - 1)) ? {~wr_q[AW], {AW{1'b0}}} : wr_q + 1'b1;
    if (pop)
      rd_n = (rd_q[AW-1:0] == AW'(DEPTH - 1)) ? {~rd_q[AW], {AW{1'b0}}} : rd_q + 1'b1;
    if (push && !accept)
      ovf_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      ovf_q <= ovf_n;
    end
  end

  // Storage carries no reset; written under an explicit enable
  always_ff @(posedge clk) begin
    if (accept)
      mem[wr_q[AW-1:0]] <= wdata;
  end

  // R8: occupancy never exceeds the buffer size
  a_r8_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= DEPTH_P);
  // R9: overflow flag is sticky
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  // R4: the serialiser never reads an empty buffer
  a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/rtoh_nibbler.sv
module rtoh_nibbler
  import rtoh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_tick,
  input  logic             empty,
  input  oh_word_t         rdata,
  output logic             pop,
  output logic [NIB_W-1:0] nib,
  output logic             vld,
  output logic             fp
);
  logic [NIB_W-1:0] nib_q, nib_n, low_q, low_n;
  logic             vld_q, vld_n, fp_q, fp_n, half_q, half_n;

  always_comb begin
    nib_n  = nib_q;
    low_n  = low_q;
    vld_n  = vld_q;
    fp_n   = fp_q;
    half_n = half_q;
    pop    = 1'b0;
    if (port_tick) begin
      if (half_q) begin
        nib_n  = low_q;
        vld_n  = 1'b1;
        fp_n   = 1'b0;
        half_n = 1'b0;
      end else if (!empty) begin
        pop    = 1'b1;
        nib_n  = rdata.octet[OCT_W-1:NIB_W];
        low_n  = rdata.octet[NIB_W-1:0];
        vld_n  = 1'b1;
        fp_n   = rdata.sof;
        half_n = 1'b1;
      end else begin
        nib_n  = '0;
        vld_n  = 1'b0;
        fp_n   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nib_q  <= '0;
      low_q  <= '0;
      vld_q  <= 1'b0;
      fp_q   <= 1'b0;
      half_q <= 1'b0;
    end else begin
      nib_q  <= nib_n;
      low_q  <= low_n;
      vld_q  <= vld_n;
      fp_q   <= fp_n;
      half_q <= half_n;
    end
  end

  assign nib = nib_q;
  assign vld = vld_q;
  assign fp  = fp_q;

  // R6: port outputs move only after a port tick
  a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !port_tick |=> ($stable(nib_q) && $stable(vld_q) && $stable(fp_q)));
  // R3: frame pulse only accompanies a valid nibble
  a_r3_fp_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fp_q |-> vld_q);
  // R2: the low half follows on the very next slot, never flagged
  a_r2_low_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (port_tick && half_q) |=> (vld_q && !fp_q));
endmodule

// File: rtl/rtoh_extract.sv
module rtoh_extract
  import rtoh_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic       in_oh,
  input  logic       in_sof,
  input  logic       port_tick,
  input  logic       valid_pol,
  output logic [3:0] toh_nib,
  output logic       toh_valid,
  output logic       toh_fp,
  output logic       ovf_err
);
  oh_word_t wdata, rdata;
  logic     push, pop, empty, vld;

  assign push  = in_valid && in_oh;
  assign wdata = '{sof: in_sof, octet: in_byte};

  rtoh_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .wdata   (wdata),
    .pop     (pop),
    .rdata   (rdata),
    .empty   (empty),
    .ovf_err (ovf_err)
  );

  rtoh_nibbler u_nib (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_tick (port_tick),
    .empty     (empty),
    .rdata     (rdata),
    .pop       (pop),
    .nib       (toh_nib),
    .vld       (vld),
    .fp        (toh_fp)
  );

  assign toh_valid = valid_pol ? vld : ~vld;

  // R4: idle slots carry a zero nibble
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> (toh_nib == '0 && !toh_fp));
endmodule

// File: tb/rtoh_extract_tb.sv
module rtoh_extract_tb;
  localparam int DEPTH = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_oh = 1'b0, in_sof = 1'b0;
  logic [7:0] in_byte = '0;
  logic       port_tick = 1'b0;
  logic       valid_pol = 1'b1;
  logic [3:0] toh_nib;
  logic       toh_valid, toh_fp, ovf_err;

  rtoh_extract #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_oh(in_oh), .in_sof(in_sof), .port_tick(port_tick),
    .valid_pol(valid_pol), .toh_nib(toh_nib), .toh_valid(toh_valid),
    .toh_fp(toh_fp), .ovf_err(ovf_err)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int tick_div = 2, tick_cnt = 0;
  logic tick_seen = 1'b0;
  int cap_nib [4096];
  bit cap_fp  [4096];
  int ncap = 0, idle = 0, idle_bad = 0, hold_bad = 0;
  int exp_nib [4096];
  bit exp_fp  [4096];
  int nexp = 0;
  logic [3:0] last_nib = '0;
  logic last_act = 1'b0, last_fp = 1'b0;

  // Port tick generator
  always @(negedge clk) begin
    if (tick_div == 0) port_tick = 1'b0;
    else begin
      tick_cnt = tick_cnt + 1;
      if (tick_cnt >= tick_div) begin tick_cnt = 0; port_tick = 1'b1; end
      else port_tick = 1'b0;
    end
  end

  always @(posedge clk) tick_seen <= port_tick;

  // Collector: outputs are fresh one edge after a tick
  always @(negedge clk) begin
    logic act;
    act = (toh_valid === valid_pol);
    if (rst_n) begin
      if (tick_seen) begin
        if (act) begin
          cap_nib[ncap] = int'(toh_nib); cap_fp[ncap] = toh_fp; ncap = ncap + 1;
        end else begin
          idle = idle + 1;
          if (toh_nib !== 4'h0 || toh_fp !== 1'b0) idle_bad = idle_bad + 1;
        end
      end else if (toh_nib !== last_nib || act !== last_act || toh_fp !== last_fp)
        hold_bad = hold_bad + 1;
    end
    last_nib = toh_nib; last_act = act; last_fp = toh_fp;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic add_exp(input logic [7:0] b, input bit sof);
    exp_nib[nexp] = int'(b[7:4]); exp_fp[nexp] = sof;
    exp_nib[nexp+1] = int'(b[3:0]); exp_fp[nexp+1] = 1'b0;
    nexp = nexp + 2;
  endtask

  task automatic offer(input logic [7:0] b, input bit sof, input bit oh, input bit v);
    @(negedge clk);
    in_byte = b; in_sof = sof; in_oh = oh; in_valid = v;
    @(negedge clk);
    in_valid = 1'b0; in_oh = 1'b0; in_sof = 1'b0;
  endtask

  task automatic compare(input int start, input string req);
    int bad = 0, fbad = 0;
    chk(ncap - start == nexp, {req, " nibble count"}, ncap - start, nexp);
    for (int i = 0; i < nexp && i < ncap - start; i++) begin
      if (cap_nib[start+i] != exp_nib[i]) bad = bad + 1;
      if (cap_fp[start+i] != exp_fp[i]) fbad = fbad + 1;
    end
    chk(bad == 0, {req, " nibble order/content mismatches"}, bad, 0);
    chk(fbad == 0, {req, " frame pulse mismatches"}, fbad, 0);
  endtask

  task automatic drain(input int cycles);
    repeat (cycles) @(negedge clk);
  endtask

  task automatic t_reset;
    // R10
    chk(toh_nib == 4'h0, "R10 nib after reset", int'(toh_nib), 0);
    chk(toh_fp == 1'b0, "R10 fp after reset", int'(toh_fp), 0);
    chk(ovf_err == 1'b0, "R10 ovf_err after reset", int'(ovf_err), 0);
    chk(toh_valid == 1'b0, "R10 valid inactive after reset", int'(toh_valid), 0);
    drain(20);
    chk(ncap == 0, "R10 buffer empty: no data after reset", ncap, 0);
  endtask

  task automatic t_basic;
    // R1 R2 R3: a frame start then a few overhead bytes
    int start = ncap;
    nexp = 0;
    offer(8'hF6, 1, 1, 1); add_exp(8'hF6, 1);
    offer(8'hF6, 0, 1, 1); add_exp(8'hF6, 0);
    offer(8'h28, 0, 1, 1); add_exp(8'h28, 0);
    offer(8'hA5, 0, 1, 1); add_exp(8'hA5, 0);
    offer(8'h3C, 0, 1, 1); add_exp(8'h3C, 0);
    drain(40);
    compare(start, "R1/R2/R3 basic");
  endtask

  task automatic t_ignore;
    // R7: payload bytes and unstrobed bytes are not forwarded
    int start = ncap;
    nexp = 0;
    offer(8'h11, 0, 1, 1); add_exp(8'h11, 0);
    offer(8'h99, 0, 0, 1);
    offer(8'h77, 1, 1, 0);
    offer(8'h22, 0, 0, 1);
    offer(8'h33, 0, 1, 1); add_exp(8'h33, 0);
    drain(40);
    compare(start, "R7 ignore non-overhead");
    chk(idle_bad == 0, "R4 idle slots zero", idle_bad, 0);
  endtask

  task automatic t_burst;
    // R8: one full overhead row back to back, slow port
    int start = ncap;
    nexp = 0;
    tick_div = 3;
    @(negedge clk);
    for (int i = 0; i < 144; i++) begin
      in_byte = 8'((i * 37 + 5) & 8'hFF); in_sof = (i == 0); in_oh = 1'b1; in_valid = 1'b1;
      add_exp(8'((i * 37 + 5) & 8'hFF), i == 0);
      @(negedge clk);
    end
    in_valid = 1'b0; in_oh = 1'b0; in_sof = 1'b0;
    drain(144 * 2 * 3 + 30);
    compare(start, "R8 row burst");
    chk(ovf_err == 1'b0, "R8 no overflow on row burst", int'(ovf_err), 0);
    chk(idle > 0 && idle_bad == 0, "R4 idle slots inactive and zero", idle_bad, 0);
    tick_div = 2;
  endtask

  task automatic t_polarity;
    // R5: active-low valid
    int start, idle0;
    nexp = 0;
    @(posedge clk); #1 valid_pol = 1'b0;
    @(negedge clk);
    chk(toh_valid == 1'b1, "R5 idle level high when active-low", int'(toh_valid), 1);
    start = ncap; idle0 = idle;
    offer(8'hC3, 0, 1, 1); add_exp(8'hC3, 0);
    offer(8'h5A, 0, 1, 1); add_exp(8'h5A, 0);
    drain(30);
    compare(start, "R5 active-low data");
    @(posedge clk); #1 valid_pol = 1'b1;
    @(negedge clk);
    chk(toh_valid == 1'b0, "R5 idle level low when active-high", int'(toh_valid), 0);
    chk(hold_bad == 0, "R6 outputs change only after ticks", hold_bad, 0);
  endtask

  task automatic t_overflow;
    // R9: port stalled, buffer overrun
    int start = ncap;
    nexp = 0;
    tick_div = 0;
    drain(4);
    chk(ovf_err == 1'b0, "R9 flag clear before overrun", int'(ovf_err), 0);
    @(negedge clk);
    for (int i = 0; i < DEPTH + 3; i++) begin
      in_byte = 8'(i); in_sof = 1'b0; in_oh = 1'b1; in_valid = 1'b1;
      if (i < DEPTH) add_exp(8'(i), 0);
      @(negedge clk);
    end
    in_valid = 1'b0; in_oh = 1'b0;
    chk(ovf_err == 1'b1, "R9 flag set on overrun", int'(ovf_err), 1);
    tick_div = 2;
    drain(DEPTH * 2 * 2 + 40);
    compare(start, "R9 held bytes survive overrun");
    chk(ovf_err == 1'b1, "R9 flag sticky after drain", int'(ovf_err), 1);
    chk(hold_bad == 0, "R6 outputs change only after ticks", hold_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_ignore();
    t_burst();
    t_polarity();
    t_overflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule